// File: doc/BRIEF.md
# Mirrored Interrupt Status Combiner

This block keeps the per-channel interrupt status flags of a two-channel disk controller and drives its single PCI interrupt line. Each channel's flag is held twice, once in a legacy status byte and once in a shared mode byte. The two copies must always read back the same value. A flag follows its channel's interrupt input: it is set when the input rises and cleared when the input falls. Software clears a flag by writing a 1 to either of its copies through the byte-wide configuration port. A write to a legacy byte copies the legacy flags into the mode byte. A write to the mode byte copies its flags back out to the legacy bytes.

The mode byte also holds one block bit per channel. These bits can be loaded only from the bus-master window's update port. The interrupt line is the OR over both channels of the flag AND NOT the channel's block bit.

The block also serves a few fixed configuration bytes: the channel-enable byte, the interrupt pin byte and the programming-interface byte. Multi-byte configuration writes reach this block one byte per cycle, in ascending address order.

Top module: `irq_mirror_combiner`

## Requirements
- R1: In the first cycle after a synchronous reset, every flag and block bit reads 0 and `irq_o` is low. Byte 0x51 reads 0x04, or 0x0C when `SECONDARY_EN` is 1.
- R2: The following bytes read fixed values that configuration writes never change: 0x3D reads 0x01, 0x09 reads 0x8F and 0x51 reads as in R1. Any address that is not implemented reads 0x00.
- R3: A rising edge on `chan_irq[c]` sets channel c's flag in both copies in the next cycle, and a falling edge clears it. Channel 0's copies are byte 0x50 bit 2 and byte 0x71 bit 2. Channel 1's copies are byte 0x57 bit 4 and byte 0x71 bit 3.
- R4: Writing a byte clears a flag only where the written data has a 1 at that flag's bit: byte 0x50 bit 2 clears channel 0, byte 0x57 bit 4 clears channel 1, and byte 0x71 bits 2 and 3 clear channels 0 and 1. A written 0 leaves the flag unchanged.
- R5: Configuration writes never set any bit of bytes 0x50, 0x57 or 0x71, and never change the block bits.
- R6: A pulse on `blk_wr` loads the block bits from `blk_wdata[4]` (channel 0) and `blk_wdata[5]` (channel 1). They read back at byte 0x71 bits 4 and 5. The other bits of `blk_wdata` are ignored.
- R7: `irq_o` equals (flag0 AND NOT block0) OR (flag1 AND NOT block1), and follows the registered state in the same cycle.
- R8: When an input edge and a write-1-to-clear of the same flag land in one cycle, the edge wins: a rising edge leaves the flag set.
- R9: The two copies of each flag always read back equal.
- R10: If a flag is cleared while its input stays high, the flag stays clear until the input next rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_irq | input | 2 | Interrupt levels of channels 1 and 0 |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_waddr | input | 8 | Configuration write byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_raddr | input | 8 | Configuration read byte address |
| cfg_rdata | output | 8 | Configuration read data, combinational |
| blk_wr | input | 1 | Block-bit update strobe from the bus-master window |
| blk_wdata | input | 8 | Block-bit update data; bits 5:4 are used |
| irq_o | output | 1 | PCI interrupt level |

## Verification
The assertions take the channel inputs to be synchronous to `clk`, so that an edge is seen as one registered change. They also assume that only one configuration byte arrives per cycle. The bench changes its inputs only at the falling clock edge and issues at most one write per cycle on each port. Its random stimulus mixes input toggles, writes to the flag bytes, writes to the fixed and unused bytes, and block updates. This reaches the cases where an edge and a clear land in the same cycle, and where both update ports are used together.

// File: rtl/irqmc_pkg.sv
`timescale 1ns/1ps
package irqmc_pkg;
  typedef logic [7:0] cfg_byte_t;

  localparam int CH_N = 2;

  localparam cfg_byte_t A_PRI0 = 8'h50;
  localparam cfg_byte_t A_ENA  = 8'h51;
  localparam cfg_byte_t A_PRI1 = 8'h57;
  localparam cfg_byte_t A_MIR  = 8'h71;
  localparam cfg_byte_t A_PIN  = 8'h3D;
  localparam cfg_byte_t A_PIF  = 8'h09;

  localparam int PRI0_BIT = 2;
  localparam int PRI1_BIT = 4;
  localparam int MIR_BASE = 2;
  localparam int BLK_BASE = 4;

  localparam cfg_byte_t PIN_VAL = 8'h01;
  localparam cfg_byte_t PIF_VAL = 8'h8F;
  localparam cfg_byte_t ENA_CH0 = 8'h04;
  localparam cfg_byte_t ENA_CH1 = 8'h08;

  function automatic cfg_byte_t pri_addr(int c);
    return (c == 0) ? A_PRI0 : A_PRI1;
  endfunction

  function automatic int pri_bit(int c);
    return (c == 0) ? PRI0_BIT : PRI1_BIT;
  endfunction

  function automatic logic line_level(logic [CH_N-1:0] flags, logic [CH_N-1:0] blocks);
    return |(flags & ~blocks);
  endfunction

  function automatic cfg_byte_t ena_value(bit secondary);
    return secondary ? (ENA_CH0 | ENA_CH1) : ENA_CH0;
  endfunction
endpackage

// File: rtl/irqmc_edge.sv
`timescale 1ns/1ps
module irqmc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/irqmc_flag_bank.sv
`timescale 1ns/1ps
module irqmc_flag_bank
  import irqmc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_N-1:0] rise,
  input  logic [CH_N-1:0] fall,
  input  logic            cfg_wr,
  input  cfg_byte_t       cfg_waddr,
  input  cfg_byte_t       cfg_wdata,
  input  logic            blk_wr,
  input  cfg_byte_t       blk_wdata,
  output logic [CH_N-1:0] pri_q,
  output logic [CH_N-1:0] mir_q,
  output logic [CH_N-1:0] blk_q
);
  logic [CH_N-1:0] hit_pri;
  logic            hit_mir;
  logic            hit_any_pri;
  logic            unused_bits;

  assign unused_bits = ^{cfg_wdata[7:5], cfg_wdata[1:0], blk_wdata[7:6], blk_wdata[3:0]};

  always_comb begin
    for (int c = 0; c < CH_N; c++) begin
      hit_pri[c] = cfg_wr && (cfg_waddr == pri_addr(c));
    end
  end
  assign hit_any_pri = |hit_pri;
  assign hit_mir     = cfg_wr && (cfg_waddr == A_MIR);

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic clr_pri, clr_mir;
    logic pri_w, mir_w;
    logic pri_r, mir_r;

    always_comb begin
      clr_pri = hit_pri[c] & cfg_wdata[pri_bit(c)];
      clr_mir = hit_mir & cfg_wdata[MIR_BASE + c];
      if (hit_mir) begin
        // mode byte written: clear there, copy outward
        mir_w = mir_r & ~clr_mir;
        pri_w = mir_w;
      end else if (hit_any_pri) begin
        // a legacy byte written: clear there, copy inward
        pri_w = pri_r & ~clr_pri;
        mir_w = pri_w;
      end else begin
        pri_w = pri_r;
        mir_w = mir_r;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pri_r <= 1'b0;
        mir_r <= 1'b0;
      end else if (rise[c]) begin
        pri_r <= 1'b1;
        mir_r <= 1'b1;
      end else if (fall[c]) begin
        pri_r <= 1'b0;
        mir_r <= 1'b0;
      end else begin
        pri_r <= pri_w;
        mir_r <= mir_w;
      end
    end

    assign pri_q[c] = pri_r;
    assign mir_q[c] = mir_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      blk_q <= '0;
    else if (blk_wr) blk_q <= blk_wdata[BLK_BASE +: CH_N];
  end
endmodule

// File: rtl/irqmc_cfg_view.sv
`timescale 1ns/1ps
module irqmc_cfg_view
  import irqmc_pkg::*;
#(
  parameter bit SECONDARY_EN = 1'b0
) (
  input  cfg_byte_t       raddr,
  input  logic [CH_N-1:0] pri,
  input  logic [CH_N-1:0] mir,
  input  logic [CH_N-1:0] blk,
  output cfg_byte_t       rdata
);
  localparam cfg_byte_t ENA_RST = ena_value(SECONDARY_EN);

  always_comb begin
    case (raddr)
      A_PRI0:  rdata = {7'b0, pri[0]} << PRI0_BIT;
      A_PRI1:  rdata = {7'b0, pri[1]} << PRI1_BIT;
      A_MIR:   rdata = ({6'b0, blk} << BLK_BASE) | ({6'b0, mir} << MIR_BASE);
      A_ENA:   rdata = ENA_RST;
      A_PIN:   rdata = PIN_VAL;
      A_PIF:   rdata = PIF_VAL;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irq_mirror_combiner.sv
`timescale 1ns/1ps
module irq_mirror_combiner
  import irqmc_pkg::*;
#(
  parameter bit SECONDARY_EN = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] chan_irq,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_waddr,
  input  logic [7:0] cfg_wdata,
  input  logic [7:0] cfg_raddr,
  output logic [7:0] cfg_rdata,
  input  logic       blk_wr,
  input  logic [7:0] blk_wdata,
  output logic       irq_o
);
  logic [CH_N-1:0] ch_rise;
  logic [CH_N-1:0] ch_fall;
  logic [CH_N-1:0] pri_flag;
  logic [CH_N-1:0] mir_flag;
  logic [CH_N-1:0] blk_bits;

  for (genvar c = 0; c < CH_N; c++) begin : g_edge
    irqmc_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (chan_irq[c]),
      .rise (ch_rise[c]),
      .fall (ch_fall[c])
    );
  end

  irqmc_flag_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (ch_rise),
    .fall     (ch_fall),
    .cfg_wr   (cfg_wr),
    .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata),
    .blk_wr   (blk_wr),
    .blk_wdata(blk_wdata),
    .pri_q    (pri_flag),
    .mir_q    (mir_flag),
    .blk_q    (blk_bits)
  );

  irqmc_cfg_view #(.SECONDARY_EN(SECONDARY_EN)) u_view (
    .raddr(cfg_raddr),
    .pri  (pri_flag),
    .mir  (mir_flag),
    .blk  (blk_bits),
    .rdata(cfg_rdata)
  );

  assign irq_o = line_level(mir_flag, blk_bits);
endmodule

// File: rtl/irqmc_checker.sv
`timescale 1ns/1ps
module irqmc_checker #(
  parameter bit SECONDARY_EN = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [7:0] cfg_waddr,
  input logic [1:0] mir_clr_bits,
  input logic       blk_wr,
  input logic [1:0] blk_sel,
  input logic [7:0] cfg_raddr,
  input logic [7:0] cfg_rdata,
  input logic       irq_o,
  input logic [1:0] ch_rise,
  input logic [1:0] ch_fall,
  input logic [1:0] pri_flag,
  input logic [1:0] mir_flag,
  input logic [1:0] blk_bits
);
  localparam logic [7:0] ENA_EXP = SECONDARY_EN ? 8'h0C : 8'h04;

  // R9
  copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_flag == mir_flag);

  // R3
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rise != 2'b00) |=> ((pri_flag & $past(ch_rise)) == $past(ch_rise)));

  // R3
  fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_fall != 2'b00) |=> ((mir_flag & $past(ch_fall)) == 2'b00));

  // R4
  mir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_waddr == 8'h71) |=> ((mir_flag & $past(mir_clr_bits & ~ch_rise)) == 2'b00));

  // R6
  blk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wr |=> (blk_bits == $past(blk_sel)));

  // R5
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_wr |=> $stable(blk_bits));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pri_flag & ~blk_bits) != 2'b00));

  // R7
  irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_bits == 2'b11) |-> !irq_o);

  // R2
  ena_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_raddr == 8'h51) |-> (cfg_rdata == ENA_EXP));
endmodule

bind irq_mirror_combiner irqmc_checker #(.SECONDARY_EN(SECONDARY_EN)) u_irqmc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_waddr   (cfg_waddr),
  .mir_clr_bits(cfg_wdata[3:2]),
  .blk_wr      (blk_wr),
  .blk_sel     (blk_wdata[5:4]),
  .cfg_raddr   (cfg_raddr),
  .cfg_rdata   (cfg_rdata),
  .irq_o       (irq_o),
  .ch_rise     (ch_rise),
  .ch_fall     (ch_fall),
  .pri_flag    (pri_flag),
  .mir_flag    (mir_flag),
  .blk_bits    (blk_bits)
);

// File: tb/test_irq_mirror_combiner.sv
`timescale 1ns/1ps
module test_irq_mirror_combiner;
  localparam bit SEC = 1'b1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chan_irq = 2'b00;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_waddr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_raddr = 8'h00;
  logic [7:0] cfg_rdata;
  logic       blk_wr = 1'b0;
  logic [7:0] blk_wdata = 8'h00;
  logic       irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit [1:0] m_flag = 2'b00;
  bit [1:0] m_blk = 2'b00;
  bit [1:0] m_prev = 2'b00;

  always #4 clk = ~clk;

  irq_mirror_combiner #(.SECONDARY_EN(SEC)) i_irq_mirror_combiner (
    .clk(clk), .rst_n(rst_n), .chan_irq(chan_irq),
    .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .blk_wr(blk_wr), .blk_wdata(blk_wdata), .irq_o(irq_o)
  );

  function automatic bit [7:0] exp_read(bit [7:0] a);
    case (a)
      8'h50:   return {5'b0, m_flag[0], 2'b0};
      8'h57:   return {3'b0, m_flag[1], 4'b0};
      8'h71:   return {2'b0, m_blk, m_flag, 2'b0};
      8'h51:   return SEC ? 8'h0C : 8'h04;
      8'h3D:   return 8'h01;
      8'h09:   return 8'h8F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit exp_irq();
    return (m_flag[0] & ~m_blk[0]) | (m_flag[1] & ~m_blk[1]);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(string req, bit [7:0] a);
    cfg_raddr = a;
    #1;
    chk(req, cfg_rdata, exp_read(a));
  endtask

  // called at a falling edge; takes 3 ns of the 4 ns half period
  task automatic check_all(string req);
    chk({req, " R7 irq"}, {7'b0, irq_o}, {7'b0, exp_irq()});
    peek({req, " R3 byte50"}, 8'h50);
    peek({req, " R3 byte57"}, 8'h57);
    peek({req, " R9 byte71"}, 8'h71);
  endtask

  task automatic rd(string req, bit [7:0] a);
    @(negedge clk);
    peek(req, a);
  endtask

  task automatic cycle(bit [1:0] in, bit wr, bit [7:0] addr, bit [7:0] data,
                       bit bw, bit [7:0] bdata);
    bit [1:0] clr;
    chan_irq = in; cfg_wr = wr; cfg_waddr = addr; cfg_wdata = data;
    blk_wr = bw; blk_wdata = bdata;
    @(posedge clk);
    clr[0] = wr && (((addr == 8'h50) && data[2]) || ((addr == 8'h71) && data[2]));
    clr[1] = wr && (((addr == 8'h57) && data[4]) || ((addr == 8'h71) && data[3]));
    for (int c = 0; c < 2; c++) begin
      if (in[c] && !m_prev[c])      m_flag[c] = 1'b1;
      else if (!in[c] && m_prev[c]) m_flag[c] = 1'b0;
      else if (clr[c])              m_flag[c] = 1'b0;
    end
    if (bw) m_blk = bdata[5:4];
    m_prev = in;
    #1;
    cfg_wr = 1'b0;
    blk_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [7:0] a;
    bit [1:0] in;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1 reset");
    rd("R1 enable byte", 8'h51);
    // R2 fixed bytes
    rd("R2 pin byte", 8'h3D);
    rd("R2 progif byte", 8'h09);
    rd("R2 unused byte", 8'h00);

    // R3 rising edge on channel 0
    cycle(2'b01, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
    check_all("R3 rise ch0");

    // R4 zero bits do not clear
    cycle(2'b01, 1'b1, 8'h50, 8'hFB, 1'b0, 8'h00);
    check_all("R4 write zero bit2");
    // R4 clear via 0x50, R10 input still high
    cycle(2'b01, 1'b1, 8'h50, 8'h04, 1'b0, 8'h00);
    check_all("R4 clear via 50");
    repeat (3) cycle(2'b01, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
    check_all("R10 held high stays clear");

    // R8 rise on ch1 with same-cycle clear through 0x71
    cycle(2'b11, 1'b1, 8'h71, 8'h08, 1'b0, 8'h00);
    check_all("R8 set wins");

    // R6 block both channels
    cycle(2'b11, 1'b0, 8'h00, 8'h00, 1'b1, 8'h30);
    check_all("R6 block both");

    // R5 full-ones write to 0x71 keeps block bits, clears ch1
    cycle(2'b11, 1'b1, 8'h71, 8'hFF, 1'b0, 8'h00);
    check_all("R5 ones to 71");
    // R5 write to 0x57 sets nothing
    cycle(2'b11, 1'b1, 8'h57, 8'hEF, 1'b0, 8'h00);
    check_all("R5 no set via 57");

    // R2 enable byte ignores writes
    cycle(2'b11, 1'b1, 8'h51, 8'hFF, 1'b0, 8'h00);
    rd("R2 enable after write", 8'h51);

    // R6 other data bits ignored
    cycle(2'b00, 1'b0, 8'h00, 8'h00, 1'b1, 8'hCF);
    check_all("R6 ignore others");
    cycle(2'b10, 1'b0, 8'h00, 8'h00, 1'b1, 8'h10);
    check_all("R7 ch1 unblocked");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      in = chan_irq;
      if ($urandom % 4 == 0) in[0] = ~in[0];
      if ($urandom % 4 == 0) in[1] = ~in[1];
      case ($urandom % 6)
        0: a = 8'h50;
        1: a = 8'h57;
        2: a = 8'h71;
        3: a = 8'h51;
        4: a = 8'h3D;
        default: a = 8'($urandom);
      endcase
      cycle(in, ($urandom % 2) == 1, a, 8'($urandom), ($urandom % 5) == 0, 8'($urandom));
      check_all("R3 R4 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule